// File: doc/BRIEF.md
# RTC Command and Interrupt Controller

This block holds the 8-bit command register of a real-time clock and turns two alarm events into two interrupt pins. One event is a single-cycle strobe that fires when the time of day matches the programmed alarm. The other is a single-cycle strobe that fires when the watchdog countdown expires. Both strobes come from logic outside this block, which only records, masks, routes and signals them.

Each event sets a sticky flag in the command register. Software cannot clear a flag by writing to it. A flag clears as a side effect when the bus touches, by read or write, one of the registers that belong to its source. Configuration bits choose which event drives which pin, whether each event may reach a pin at all, the active level of the second pin, and whether pins signal with a held level or with a pulse about three milliseconds long. The pulse length is timed by a 1 kHz tick input. Each pin is driven by its own small state machine with the states `PIN_IDLE`, `PIN_LEVEL` and `PIN_PULSE`:

- `PIN_IDLE` goes to `PIN_LEVEL` in level mode when the routed condition (flag set and source unmasked) is true.
- `PIN_IDLE` goes to `PIN_PULSE` in pulse mode when an unmasked routed strobe arrives.
- `PIN_LEVEL` goes back to `PIN_IDLE` when the condition drops or pulse mode is selected.
- `PIN_PULSE` goes back to `PIN_IDLE` on the third tick. If level mode is selected while a pulse is running, it goes to `PIN_LEVEL` when the condition is true and to `PIN_IDLE` otherwise.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the command register reads 0x00, `update_en_o` is 0, and both pins are at logic 1 (their inactive level).
- R2: A bus write to address 0xB loads command bits 7..2 from the write data. Write data bits 1..0 are ignored. A read at 0xB returns the command register, and a read at any other address returns 0x00.
- R3: A time-of-day strobe sets command bit 0 whatever the mask bits are. Bit 0 never rises without a strobe. Any access, read or write, at address 0x3, 0x5 or 0x7 clears bit 0, except that a strobe in the same cycle wins and the bit stays 1.
- R4: A watchdog strobe sets command bit 1 whatever the mask bits are. Any access at address 0xC or 0xD clears bit 1, except that a watchdog strobe in the same cycle wins.
- R5: With command bit 6 = 1, pin A carries the time-of-day event and pin B carries the watchdog event. With bit 6 = 0 the roles are swapped.
- R6: Command bit 3 = 1 keeps the watchdog event off the pins, and bit 2 = 1 keeps the time-of-day event off the pins. A masked event still sets its flag.
- R7: Pin A always asserts low. Pin B asserts high when command bit 5 = 1 and low when it is 0.
- R8: In level mode (command bit 4 = 0), a pin asserts one cycle after its routed flag is 1 and unmasked. It stays asserted while that holds and releases one cycle after the flag clears or the source is masked.
- R9: In pulse mode (bit 4 = 1), an unmasked routed strobe asserts the pin from the next clock edge. The pin releases at the edge that samples the third `tick_i` pulse. Further strobes during a pulse neither restart nor extend it.
- R10: `update_en_o` follows command bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe for the current cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data: the command register at 0xB, otherwise 0 |
| tod_hit_i | input | 1 | Time-of-day match strobe |
| wdog_hit_i | input | 1 | Watchdog timeout strobe |
| tick_i | input | 1 | 1 kHz timing tick, one cycle wide |
| update_en_o | output | 1 | Time-register update enable (command bit 7) |
| pin_a_o | output | 1 | Interrupt pin A, active low |
| pin_b_o | output | 1 | Interrupt pin B, polarity set by command bit 5 |

## Verification
A flag that fails to set or clear shows up on the command read-back in the next cycle. In level mode it also shows up on a pin one cycle later. A wrong routing, mask or polarity choice is visible on the pins in the same cycle that the state machine state changes. A pin state machine that miscounts ticks or restarts its pulse holds its pin for the wrong number of ticks, so the bench sweeps every routing, polarity and mask combination against each event pattern and compares the pins with values computed from those bits.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    // Command register field positions (bit order is software-visible)
    localparam int unsigned CMD_W     = 8;
    localparam int unsigned BIT_UPD   = 7;
    localparam int unsigned BIT_SWAP  = 6;
    localparam int unsigned BIT_BHIGH = 5;
    localparam int unsigned BIT_PULSE = 4;
    localparam int unsigned BIT_WMASK = 3;
    localparam int unsigned BIT_TMASK = 2;
    localparam int unsigned BIT_WFLAG = 1;
    localparam int unsigned BIT_TFLAG = 0;

    // Number of interrupt pins; index 0 is pin A, index 1 is pin B
    localparam int unsigned NUM_PINS  = 2;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'd0,
        PIN_LEVEL = 2'd1,
        PIN_PULSE = 2'd2
    } pin_state_e;

endpackage

// File: rtl/rtc_cmd_regs.sv
module rtc_cmd_regs
    import rtc_irq_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 4,
    parameter logic [ADDR_W-1:0]  CMD_ADDR = 'hB,
    parameter logic [ADDR_W-1:0]  TOD_A0   = 'h3,
    parameter logic [ADDR_W-1:0]  TOD_A1   = 'h5,
    parameter logic [ADDR_W-1:0]  TOD_A2   = 'h7,
    parameter logic [ADDR_W-1:0]  WD_A0    = 'hC,
    parameter logic [ADDR_W-1:0]  WD_A1    = 'hD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              tod_hit,
    input  logic              wd_hit,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [CMD_W-1:0]  rdata
);

    localparam int unsigned CFG_LO = BIT_TMASK;
    localparam int unsigned CFG_W  = CMD_W - CFG_LO;

    logic [CFG_W-1:0] cfg_q;
    logic             tflag_q;
    logic             wflag_q;
    logic             cfg_wr;
    logic             tod_touch;
    logic             wd_touch;
    logic             wdata_unused;

    // Flag bits of the write data are discarded on purpose
    assign wdata_unused = ^wdata[CFG_LO-1:0];

    always_comb begin
        cfg_wr    = sel && we && (addr == CMD_ADDR);
        tod_touch = sel && ((addr == TOD_A0) || (addr == TOD_A1) || (addr == TOD_A2));
        wd_touch  = sel && ((addr == WD_A0) || (addr == WD_A1));
    end

    // Configuration field: only software writes change it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= wdata[CMD_W-1:CFG_LO];
        end
    end

    // Sticky flags: a strobe wins over a same-cycle clearing access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tflag_q <= 1'b0;
        end else if (tod_hit) begin
            tflag_q <= 1'b1;
        end else if (tod_touch) begin
            tflag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wflag_q <= 1'b0;
        end else if (wd_hit) begin
            wflag_q <= 1'b1;
        end else if (wd_touch) begin
            wflag_q <= 1'b0;
        end
    end

    always_comb begin
        cmd_q            = '0;
        cmd_q[CMD_W-1:CFG_LO] = cfg_q;
        cmd_q[BIT_WFLAG] = wflag_q;
        cmd_q[BIT_TFLAG] = tflag_q;
    end

    always_comb begin
        if (sel && !we && (addr == CMD_ADDR)) begin
            rdata = cmd_q;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/rtc_irq_route.sv
module rtc_irq_route
    import rtc_irq_pkg::*;
(
    input  logic [CMD_W-1:0]    cmd,
    input  logic                tod_hit,
    input  logic                wd_hit,
    output logic [NUM_PINS-1:0] lvl_cond,
    output logic [NUM_PINS-1:0] trig
);

    logic tod_lvl;
    logic wd_lvl;
    logic tod_trg;
    logic wd_trg;

    // Mask gates only the pin path; flags are untouched here
    always_comb begin
        tod_lvl = cmd[BIT_TFLAG] && !cmd[BIT_TMASK];
        wd_lvl  = cmd[BIT_WFLAG] && !cmd[BIT_WMASK];
        tod_trg = tod_hit && !cmd[BIT_TMASK];
        wd_trg  = wd_hit  && !cmd[BIT_WMASK];
    end

    // Swap bit set: pin A <- time-of-day, pin B <- watchdog
    always_comb begin
        if (cmd[BIT_SWAP]) begin
            lvl_cond = {wd_lvl,  tod_lvl};
            trig     = {wd_trg,  tod_trg};
        end else begin
            lvl_cond = {tod_lvl, wd_lvl};
            trig     = {tod_trg, wd_trg};
        end
    end

endmodule

// File: rtl/rtc_pin_fsm.sv
module rtc_pin_fsm
    import rtc_irq_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_mode,
    input  logic lvl_cond,
    input  logic trig,
    input  logic tick,
    output logic active
);

    localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PULSE_TICKS - 1);

    pin_state_e       state_q;
    pin_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (pulse_mode) begin
                    if (trig) begin
                        state_d = PIN_PULSE;
                        cnt_d   = '0;
                    end
                end else if (lvl_cond) begin
                    state_d = PIN_LEVEL;
                end
            end
            PIN_LEVEL: begin
                if (pulse_mode || !lvl_cond) begin
                    state_d = PIN_IDLE;
                end
            end
            PIN_PULSE: begin
                if (!pulse_mode) begin
                    state_d = lvl_cond ? PIN_LEVEL : PIN_IDLE;
                end else if (tick) begin
                    if (cnt_q == LAST_TICK) begin
                        state_d = PIN_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = PIN_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        active = (state_q != PIN_IDLE);
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 4,
    parameter logic [ADDR_W-1:0]  CMD_ADDR    = 'hB,
    parameter logic [ADDR_W-1:0]  TOD_A0      = 'h3,
    parameter logic [ADDR_W-1:0]  TOD_A1      = 'h5,
    parameter logic [ADDR_W-1:0]  TOD_A2      = 'h7,
    parameter logic [ADDR_W-1:0]  WD_A0       = 'hC,
    parameter logic [ADDR_W-1:0]  WD_A1       = 'hD,
    parameter int unsigned        PULSE_TICKS = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              tod_hit_i,
    input  logic              wdog_hit_i,
    input  logic              tick_i,
    output logic              update_en_o,
    output logic              pin_a_o,
    output logic              pin_b_o
);

    logic [CMD_W-1:0]    cmd_q;
    logic [NUM_PINS-1:0] lvl_cond;
    logic [NUM_PINS-1:0] trig;
    logic [NUM_PINS-1:0] pin_act;

    rtc_cmd_regs #(
        .ADDR_W   (ADDR_W),
        .CMD_ADDR (CMD_ADDR),
        .TOD_A0   (TOD_A0),
        .TOD_A1   (TOD_A1),
        .TOD_A2   (TOD_A2),
        .WD_A0    (WD_A0),
        .WD_A1    (WD_A1)
    ) regs_i (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .sel     (bus_sel_i),
        .we      (bus_we_i),
        .addr    (bus_addr_i),
        .wdata   (bus_wdata_i),
        .tod_hit (tod_hit_i),
        .wd_hit  (wdog_hit_i),
        .cmd_q   (cmd_q),
        .rdata   (bus_rdata_o)
    );

    rtc_irq_route route_i (
        .cmd      (cmd_q),
        .tod_hit  (tod_hit_i),
        .wd_hit   (wdog_hit_i),
        .lvl_cond (lvl_cond),
        .trig     (trig)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        rtc_pin_fsm #(
            .PULSE_TICKS (PULSE_TICKS)
        ) fsm_i (
            .clk        (clk_i),
            .rst_n      (rst_ni),
            .pulse_mode (cmd_q[BIT_PULSE]),
            .lvl_cond   (lvl_cond[p]),
            .trig       (trig[p]),
            .tick       (tick_i),
            .active     (pin_act[p])
        );
    end

    // Pin drivers: A is fixed active-low, B polarity is programmable
    always_comb begin
        update_en_o = cmd_q[BIT_UPD];
        pin_a_o     = !pin_act[0];
        pin_b_o     = cmd_q[BIT_BHIGH] ? pin_act[1] : !pin_act[1];
    end

endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
    parameter int unsigned        ADDR_W = 4,
    parameter logic [ADDR_W-1:0]  WD_A0  = 'hC,
    parameter logic [ADDR_W-1:0]  WD_A1  = 'hD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tod_hit,
    input logic              wd_hit,
    input logic              sel,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        cmd,
    input logic [1:0]        lvl_cond,
    input logic [1:0]        act
);

    // R3: a time-of-day strobe leaves the flag set on the next cycle
    assert_tod_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tod_hit |=> cmd[0]);

    // R3: the flag never rises without a strobe
    assert_tod_flag_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd[0]) |-> $past(tod_hit));

    // R4: a watchdog-register access without a strobe clears the flag
    assert_wd_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && ((addr == WD_A0) || (addr == WD_A1)) && !wd_hit) |=> !cmd[1]);

    // R8: in level mode pin A releases one cycle after its condition drops
    assert_level_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd[4] && !lvl_cond[0]) |=> !act[0]);

    // R6: both sources masked in level mode for two cycles keeps pins quiet
    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd[4] && cmd[3] && cmd[2] && $past(!cmd[4] && cmd[3] && cmd[2]))
            |-> (act == 2'b00));

endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WD_A0  (WD_A0),
    .WD_A1  (WD_A1)
) chk_i (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .tod_hit  (tod_hit_i),
    .wd_hit   (wdog_hit_i),
    .sel      (bus_sel_i),
    .addr     (bus_addr_i),
    .cmd      (cmd_q),
    .lvl_cond (lvl_cond),
    .act      (pin_act)
);

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CMD = 4'hB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tod = 1'b0;
    logic       wd = 1'b0;
    logic       tick = 1'b0;
    logic       upd;
    logic       pin_a;
    logic       pin_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_irq_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tod_hit_i   (tod),
        .wdog_hit_i  (wd),
        .tick_i      (tick),
        .update_en_o (upd),
        .pin_a_o     (pin_a),
        .pin_b_o     (pin_b)
    );

    task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic fire(input logic t, input logic w);
        @(negedge clk);
        tod = t; wd = w;
        @(negedge clk);
        tod = 1'b0; wd = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_flags();
        logic [7:0] d;
        bus_wr(4'h3, 8'h00);
        bus_rd(4'hC, d);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Expected {pin_b, pin_a} from active flags of each pin
    function automatic logic [7:0] pins_of(input logic [7:0] cmd, input logic act_a, input logic act_b);
        logic pa;
        logic pb;
        pa = !act_a;
        pb = cmd[5] ? act_b : !act_b;
        return {6'b0, pb, pa};
    endfunction

    // Level mode: active pin = routed flag & unmasked
    function automatic logic [7:0] lvl_pins(input logic [7:0] cmd, input logic tf, input logic wf);
        logic t;
        logic w;
        t = tf && !cmd[2];
        w = wf && !cmd[3];
        return cmd[6] ? pins_of(cmd, t, w) : pins_of(cmd, w, t);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] cfg;

        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held and after release
        check("R1 pins in reset", {6'b0, pin_b, pin_a}, 8'h03);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pins after reset", {6'b0, pin_b, pin_a}, 8'h03);
        check("R1 R10 update enable after reset", {7'b0, upd}, 8'h00);
        bus_rd(A_CMD, d);
        check("R1 command after reset", d, 8'h00);

        // R2 flag bits not writable, R10 update enable
        bus_wr(A_CMD, 8'hFF);
        bus_rd(A_CMD, d);
        check("R2 write ignores flag bits", d, 8'hFC);
        check("R10 update enable set", {7'b0, upd}, 8'h01);
        bus_wr(A_CMD, 8'h03);
        bus_rd(A_CMD, d);
        check("R2 flag-only write", d, 8'h00);
        check("R10 update enable clear", {7'b0, upd}, 8'h00);
        bus_rd(4'h4, d);
        check("R2 other address reads zero", d, 8'h00);

        // R3 strobe wins over same-cycle clearing access
        @(negedge clk);
        tod = 1'b1; sel = 1'b1; we = 1'b0; addr = 4'h3;
        @(negedge clk);
        tod = 1'b0; sel = 1'b0;
        bus_rd(A_CMD, d);
        check("R3 strobe wins over clear", d, 8'h01);
        // R4 same for the watchdog flag
        @(negedge clk);
        wd = 1'b1; sel = 1'b1; we = 1'b1; addr = 4'hD;
        @(negedge clk);
        wd = 1'b0; sel = 1'b0; we = 1'b0;
        bus_rd(A_CMD, d);
        check("R4 strobe wins over clear", d, 8'h03);
        clear_flags();
        bus_rd(A_CMD, d);
        check("R3 R4 flags cleared by access", d, 8'h00);

        // Level-mode sweep: swap, B polarity, both masks, three event patterns
        for (int c = 0; c < 16; c++) begin
            for (int ev = 1; ev < 4; ev++) begin
                cfg = {1'b0, c[3], c[2], 1'b0, c[1], c[0], 2'b00};
                bus_wr(A_CMD, cfg);
                clear_flags();
                fire(ev[0], ev[1]);
                check("R8 level one-cycle latency", {6'b0, pin_b, pin_a}, lvl_pins(cfg, 1'b0, 1'b0));
                @(negedge clk);
                check("R5 R6 R7 R8 level pins", {6'b0, pin_b, pin_a}, lvl_pins(cfg, ev[0], ev[1]));
                bus_rd(A_CMD, d);
                check("R3 R4 R6 flags set regardless of mask", d, cfg | {6'b0, ev[1], ev[0]});
                bus_wr(4'h7, 8'h00);
                @(negedge clk);
                check("R3 R8 release after time-of-day clear", {6'b0, pin_b, pin_a}, lvl_pins(cfg, 1'b0, ev[1]));
                bus_rd(4'hD, d);
                @(negedge clk);
                check("R4 R8 release after watchdog clear", {6'b0, pin_b, pin_a}, lvl_pins(cfg, 1'b0, 1'b0));
            end
        end

        // Pulse-mode sweep: swap and B polarity, each source
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                logic act_a;
                logic act_b;
                cfg = {1'b0, c[1], c[0], 1'b1, 4'b0000};
                bus_wr(A_CMD, cfg);
                clear_flags();
                act_a = c[1] ? (s == 0) : (s == 1);
                act_b = c[1] ? (s == 1) : (s == 0);
                fire(s == 0, s == 1);
                check("R5 R7 R9 pulse start", {6'b0, pin_b, pin_a}, pins_of(cfg, act_a, act_b));
                tick_once();
                tick_once();
                check("R9 pulse held after two ticks", {6'b0, pin_b, pin_a}, pins_of(cfg, act_a, act_b));
                fire(s == 0, s == 1);
                tick_once();
                check("R9 pulse ends at third tick without restart", {6'b0, pin_b, pin_a}, pins_of(cfg, 1'b0, 1'b0));
            end
        end

        // R6 masked source in pulse mode: no pulse, flag still set
        cfg = 8'h34;
        bus_wr(A_CMD, cfg);
        clear_flags();
        fire(1'b1, 1'b0);
        check("R6 masked pulse stays idle", {6'b0, pin_b, pin_a}, pins_of(cfg, 1'b0, 1'b0));
        bus_rd(A_CMD, d);
        check("R3 R6 masked flag still set", d, 8'h35);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule